// File: doc/BRIEF.md
# High-Side Overcurrent Blanking and Pulse Cut-Off

This block sits between the PWM generator of a synchronous buck controller and the high-side gate driver. It provides pulse-by-pulse current limiting. At the start of every switching cycle it raises a precondition output for a short lead-in. That output pulls the current-limit threshold node of the analog sense circuit to an intermediate level. While the precondition is held, the overcurrent comparator flag is masked. This covers the noisy interval around the switch-node rising edge.

The precondition ends adaptively. It drops as soon as the switch-node-high flag reports that the switch node has risen to near the supply. If that flag never comes, it drops when a timer of `PRE_CYC` clock cycles runs out, whichever happens first. Once the precondition is released, an overcurrent flag cuts the high-side pulse in the same clock cycle. The pulse then stays off until the next switching cycle begins. Each cycle that ends in a trip produces one single-cycle event pulse, which goes to a downstream fault counter.

Top module: `ocp_blank_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, `hs_gate_o`, `precond_o` and `oc_evt_o` are all 0.
- R2: When `cyc_start_i` is sampled high at a clock edge, `precond_o` is 1 from that edge onward. `hs_gate_o` stays 0 until the following edge, so the precondition leads the high-side pulse by one clock.
- R3: If `sw_high_i` is sampled high while `precond_o` is 1 and no new cycle starts, `precond_o` goes to 0 at that edge.
- R4: Without `sw_high_i`, `precond_o` stays high for exactly `PRE_CYC` clock cycles per switching cycle.
- R5: While `precond_o` is 1, `oc_flag_i` has no effect. `hs_gate_o` follows `pwm_req_i`, and no event is raised.
- R6: After release, `oc_flag_i` high while the high side is on forces `hs_gate_o` to 0 in the same cycle, with no register in the path.
- R7: After a trip, `hs_gate_o` stays 0 for the rest of the switching cycle, even if `oc_flag_i` drops and `pwm_req_i` stays high. It turns on again only after the next `cyc_start_i`.
- R8: A trip gives exactly one `oc_evt_o` pulse, one clock long, on the edge after the trip cycle. A switching cycle never holds more than one event.
- R9: If `pwm_req_i` falls before the precondition is released, the pulse ends normally. The high side stays off for the rest of that cycle, and a later `oc_flag_i` raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_start_i | input | 1 | One-clock pulse that begins a switching cycle |
| pwm_req_i | input | 1 | High-side request from the PWM comparator |
| sw_high_i | input | 1 | Switch node has risen to near the supply |
| oc_flag_i | input | 1 | Overcurrent comparator output |
| hs_gate_o | output | 1 | Gated high-side drive command |
| precond_o | output | 1 | Pulls the limit threshold node to its intermediate level |
| oc_evt_o | output | 1 | One-clock pulse per cycle that ended in a trip |

## Verification
The assertions assume that `cyc_start_i` is a single-clock pulse. They also assume that switching cycles are longer than the precondition window plus two clocks, so that a release and a possible trip fit within one cycle. The stimulus generates one start pulse per cycle, with cycle lengths of at least eight clocks against a five-clock timeout. The switch-high flag, the request width and the overcurrent timing are drawn at random inside each cycle, including values outside the window. This makes both release paths, early request ends and masked overcurrent all occur.

// File: rtl/ocp_pkg.sv
// Shared definitions for the overcurrent blanking block.
// Assumes nothing beyond a synchronous single-clock environment.
package ocp_pkg;

    typedef enum logic {
        PH_OPEN = 1'b0,
        PH_HOLD = 1'b1
    } pre_phase_t;

    // Width needed to count 0..n inclusive
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ocp_precond_timer.sv
// Precondition window controller.
// Raises the precondition on a cycle start. Drops it on the first switch-high
// sample, or after PRE_CYC clocks. Also delays the start pulse by one clock
// for the gate stage.
// Assumes cyc_start is a one-clock pulse and PRE_CYC >= 1.
module ocp_precond_timer
    import ocp_pkg::*;
#(
    parameter int unsigned PRE_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic sw_high,
    output logic precond,
    output logic start_d
);
    localparam int unsigned CNT_W = cnt_width(PRE_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRE_CYC - 1);

    pre_phase_t       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start_q;

    // Window state and lead counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_OPEN;
            cnt_q   <= '0;
        end else if (cyc_start) begin
            phase_q <= PH_HOLD;
            cnt_q   <= '0;
        end else if (phase_q == PH_HOLD) begin
            if (sw_high || cnt_q == LAST) begin
                phase_q <= PH_OPEN;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // One-clock delayed start, used to open the gate after the lead
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= cyc_start;
    end

    assign precond = (phase_q == PH_HOLD);
    assign start_d = start_q;
endmodule

// File: rtl/ocp_pulse_gate.sv
// High-side pulse gate with overcurrent cut-off.
// Passes the PWM request once the cycle is open. Masks the overcurrent flag
// during the precondition. Cuts the pulse combinationally on a trip, and
// latches the off state until the next cycle start.
// Assumes one PWM pulse per switching cycle.
module ocp_pulse_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic start_d,
    input  logic precond,
    input  logic pwm_req,
    input  logic oc_flag,
    output logic hs_gate,
    output logic oc_evt
);
    logic open_q;
    logic trip_q;
    logic done_q;
    logic evt_q;
    logic hold_off;
    logic trip_now;

    // Sensing is live only after release; trips only count while on
    always_comb begin
        hold_off = trip_q | done_q;
        trip_now = open_q & ~hold_off & pwm_req & oc_flag & ~precond;
        hs_gate  = open_q & ~hold_off & pwm_req & ~trip_now;
    end

    // Per-cycle open / tripped / finished state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            trip_q <= 1'b0;
            done_q <= 1'b0;
        end else if (cyc_start) begin
            open_q <= 1'b0;
            trip_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (start_d)            open_q <= 1'b1;
            if (trip_now)           trip_q <= 1'b1;
            if (open_q && !pwm_req) done_q <= 1'b1;
        end
    end

    // Single event pulse toward the fault counter
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= trip_now;
    end

    assign oc_evt = evt_q;
endmodule

// File: rtl/ocp_blank_gate.sv
// Top of the pulse-by-pulse overcurrent limiter.
// Combines the precondition timer and the pulse gate.
// Assumes the switching cycle is longer than PRE_CYC + 2 clocks.
module ocp_blank_gate #(
    parameter int unsigned PRE_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start_i,
    input  logic pwm_req_i,
    input  logic sw_high_i,
    input  logic oc_flag_i,
    output logic hs_gate_o,
    output logic precond_o,
    output logic oc_evt_o
);
    logic pre_w;
    logic start_d_w;

    ocp_precond_timer #(.PRE_CYC(PRE_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start_i),
        .sw_high   (sw_high_i),
        .precond   (pre_w),
        .start_d   (start_d_w)
    );

    ocp_pulse_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start_i),
        .start_d   (start_d_w),
        .precond   (pre_w),
        .pwm_req   (pwm_req_i),
        .oc_flag   (oc_flag_i),
        .hs_gate   (hs_gate_o),
        .oc_evt    (oc_evt_o)
    );

    assign precond_o = pre_w;
endmodule

// File: rtl/ocp_blank_gate_chk.sv
// Port-level property checker for ocp_blank_gate, attached by bind.
// Assumes a single-clock cycle-start pulse.
module ocp_blank_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_start_i,
    input logic pwm_req_i,
    input logic sw_high_i,
    input logic oc_flag_i,
    input logic hs_gate_o,
    input logic precond_o,
    input logic oc_evt_o
);
    // R2
    pre_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_i |=> (precond_o && !hs_gate_o));

    // R3
    sw_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (precond_o && sw_high_i && !cyc_start_i) |=> !precond_o);

    // R5
    masked_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_evt_o |-> !$past(precond_o));

    // R6
    cut_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!precond_o && oc_flag_i) |-> !hs_gate_o);

    // R7
    off_after_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_evt_o |-> !hs_gate_o);

    // R8
    single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_evt_o |=> !oc_evt_o);
endmodule

bind ocp_blank_gate ocp_blank_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start_i (cyc_start_i),
    .pwm_req_i   (pwm_req_i),
    .sw_high_i   (sw_high_i),
    .oc_flag_i   (oc_flag_i),
    .hs_gate_o   (hs_gate_o),
    .precond_o   (precond_o),
    .oc_evt_o    (oc_evt_o)
);

// File: tb/tb_ocp_blank_gate.sv
module tb_ocp_blank_gate;
    localparam int PRE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, pw = 1'b0, sw = 1'b0, oc = 1'b0;
    logic hs, pre, evt;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference state, derived from the requirements
    bit m_pre, m_open, m_trip, m_done, m_evt, m_sd;
    int m_cnt;

    // per-cycle port observations
    int obs_pre, obs_evt, obs_hs_after;

    always #10 clk = ~clk;

    ocp_blank_gate #(.PRE_CYC(PRE)) dut (
        .clk(clk), .rst_n(rst_n), .cyc_start_i(cs), .pwm_req_i(pw),
        .sw_high_i(sw), .oc_flag_i(oc), .hs_gate_o(hs), .precond_o(pre),
        .oc_evt_o(evt)
    );

    function automatic bit exp_trip();
        return m_open && !m_trip && !m_done && pw && oc && !m_pre;
    endfunction

    function automatic bit exp_hs();
        return m_open && !m_trip && !m_done && pw && !exp_trip();
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pre = 0; m_open = 0; m_trip = 0; m_done = 0; m_evt = 0; m_sd = 0; m_cnt = 0;
    endtask

    task automatic model_edge();
        bit t;
        t = exp_trip();
        if (cs) begin
            m_pre = 1; m_cnt = 0; m_open = 0; m_trip = 0; m_done = 0;
        end else begin
            if (m_pre) begin
                if (sw || m_cnt == PRE - 1) m_pre = 0;
                else m_cnt++;
            end
            if (m_sd) m_open = 1;
            if (t) m_trip = 1;
            if (m_open && !pw) m_done = 1;
        end
        m_evt = t;
        m_sd  = cs;
    endtask

    // one clock: drive, check gate, edge, check registered outputs
    task automatic step(input logic c, input logic p, input logic s, input logic o);
        @(negedge clk);
        cs = c; pw = p; sw = s; oc = o;
        #1;
        chk("R5 R6 R7 R9 hs_gate", hs, exp_hs());
        @(posedge clk);
        model_edge();
        #1;
        chk("R2 R3 R4 precond", pre, m_pre);
        chk("R8 oc_evt", evt, m_evt);
        if (pre) obs_pre++;
        if (evt) obs_evt++;
    endtask

    // one switching cycle of length len; pulse width d; sw after sd; oc at oa..oa+ol-1
    task automatic run_cycle(input int len, input int d, input int sd, input int oa, input int ol);
        obs_pre = 0; obs_evt = 0; obs_hs_after = 0;
        for (int k = 0; k < len; k++) begin
            step(k == 0, k < d, (k >= sd) && (k < d + 1), (k >= oa) && (k < oa + ol));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1 during reset
        chk("R1 hs in reset", hs, 1'b0);
        chk("R1 precond in reset", pre, 1'b0);
        chk("R1 evt in reset", evt, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 precond after reset", pre, 1'b0);
        chk("R1 evt after reset", evt, 1'b0);

        // R4: no switch-high flag, precondition lasts PRE clocks
        run_cycle(12, 10, 99, 99, 0);
        chk_int("R4 precond length", obs_pre, PRE);

        // R3: switch-high sampled at step 2 ends it after 2 clocks
        run_cycle(12, 10, 2, 99, 0);
        chk_int("R3 precond length early", obs_pre, 2);

        // R5: overcurrent only inside the window -> no event
        run_cycle(12, 10, 99, 1, 4);
        chk_int("R5 masked oc events", obs_evt, 0);

        // R6 R7 R8: trip after release, oc held 1 clock, request stays high
        run_cycle(14, 13, 3, 6, 1);
        chk_int("R8 one event per trip", obs_evt, 1);

        // R7: long overcurrent still gives a single event
        run_cycle(14, 13, 3, 5, 6);
        chk_int("R7 R8 long oc single event", obs_evt, 1);

        // R9: request ends at step 2 before release, oc later -> nothing
        run_cycle(14, 2, 99, 8, 3);
        chk_int("R9 early end no event", obs_evt, 0);

        // random cycles
        for (int n = 0; n < 400; n++) begin
            int len, d, sd, oa, ol;
            len = 8 + int'($urandom % 12);
            d   = int'($urandom % len);
            sd  = ($urandom % 3 == 0) ? 99 : 1 + int'($urandom % (PRE + 2));
            oa  = ($urandom % 3 == 0) ? 99 : int'($urandom % len);
            ol  = 1 + int'($urandom % 4);
            run_cycle(len, d, sd, oa, ol);
            total++;
            if (obs_evt > 1) begin
                bad++;
                $display("FAIL R8 events in one cycle act=%0d exp<=1", obs_evt);
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule